// File: doc/BRIEF.md
# Interrupt-Capable Parallel Pin Controller

This block manages a bank of general-purpose pins from a simple memory-mapped register bus. Software chooses, pin by pin, whether the pin drives or listens, whether a driving pin is push-pull or open-drain, and which kind of input transition raises an event. Driven levels come from a data register. Listening pins are brought into the clock domain through a configurable synchronizer chain, and their levels are written back into that same data register.

Each listening pin can latch a pending event, either on any level change or only on a high-to-low transition. Pending events that are enabled by a mask are ORed onto a single interrupt line. Software acknowledges an event by writing a 1 to its bit. Register bit ordering is reversed with respect to pin numbering: pin 0 sits in the most significant bit.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset all six registers read zero, every `pin_oe_o` bit is 0 and `irq_o` is 0.
- R2: A full-width access (`bus_full_i`=1) reaches the registers at these byte offsets: pin direction 0x00, open-drain enable 0x04, data 0x08, pending events 0x0C, event mask 0x10, edge select 0x14. A read returns the register value combinationally in the same cycle.
- R3: An access with `bus_full_i`=0 reads zero, and a write of that kind changes no register.
- R4: Inside the 4 KB window, offsets other than the six listed ones read zero, and writes to them change no register.
- R5: Pin n corresponds to register bit (NPINS-1-n), so pin 0 is the most significant bit.
- R6: A direction bit of 1 makes the pin an output, and `pin_out_o` follows that pin's data bit. A write to the data register stores all bits, including the bits of input pins.
- R7: When the synchronized level of an input pin changes, its data bit takes the new level, exactly SYNC_STAGES+1 rising edges after the change is presented. Level changes on output pins leave the data register unchanged.
- R8: Writing the event register clears each bit written as 1 and leaves every bit written as 0 unchanged.
- R9: `irq_o` is 1 exactly when (events AND mask) is nonzero.
- R10: With an edge-select bit of 0, any level change on that input pin sets its event bit. With the bit at 1, only a high-to-low change sets it. Output pins never set event bits.
- R11: `pin_oe_o` is 1 for a push-pull output pin. For an output pin whose open-drain bit is 1, it is 1 only while the data bit is 0. It is 0 for input pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_full_i | input | 1 | Access is full register width |
| bus_addr_i | input | ADDR_W | Byte offset within the window |
| bus_wdata_i | input | NPINS | Write data |
| bus_rdata_o | output | NPINS | Read data |
| pin_in_i | input | NPINS | External pin levels, index = pin number |
| pin_out_o | output | NPINS | Driven pin levels |
| pin_oe_o | output | NPINS | Pin output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its defaults: 32 pins and a two-stage synchronizer. With these values the register-to-pin bit reversal covers a full bus word, and the input latency is three edges, so the bench can pin down the exact cycle in which a data bit flips. Random register writes and random pin patterns mix input and output pins and both edge-select modes. This makes it possible to reach cases such as a pin that switches back to input while its stored data differs from its external level.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int WIN_AW = 12;

    typedef enum logic [2:0] {
        SEL_DIR, SEL_OD, SEL_DAT, SEL_EVT, SEL_MSK, SEL_CTL, SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_off(input logic [WIN_AW-1:0] off);
        case (off)
            12'h000: return SEL_DIR;
            12'h004: return SEL_OD;
            12'h008: return SEL_DAT;
            12'h00C: return SEL_EVT;
            12'h010: return SEL_MSK;
            12'h014: return SEL_CTL;
            default: return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] chain_q [STAGES];
    logic [W-1:0] chain_d [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_comb chain_d[s] = async_i;
        end else begin : g_next
            always_comb chain_d[s] = chain_q[s-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_d[s];
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] fall_only_i,
    output logic [W-1:0] upd_o,
    output logic [W-1:0] set_o
);
    logic [W-1:0] prev_d, prev_q;
    logic [W-1:0] chg, fall;

    always_comb begin
        chg    = level_i ^ prev_q;
        fall   = prev_q & ~level_i;
        upd_o  = chg & ~dir_i;
        set_o  = ~dir_i & ((chg & ~fall_only_i) | (fall & fall_only_i));
        prev_d = level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    // a rising sample on an input pin never raises a falling-only event
    p_fall_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_o & fall_only_i & level_i) == '0));
endmodule

// File: rtl/gpio_drive.sv
module gpio_drive #(
    parameter int W = 32
) (
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] od_i,
    input  logic [W-1:0] dat_i,
    output logic [W-1:0] out_o,
    output logic [W-1:0] oe_o
);
    always_comb begin
        out_o = dat_i;
        oe_o  = dir_i & ~(od_i & dat_i);
    end
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = WIN_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic              bus_full_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [NPINS-1:0]  bus_wdata_i,
    output logic [NPINS-1:0]  bus_rdata_o,
    input  logic [NPINS-1:0]  pin_in_i,
    output logic [NPINS-1:0]  pin_out_o,
    output logic [NPINS-1:0]  pin_oe_o,
    output logic              irq_o
);
    localparam int TOP = NPINS - 1;

    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] od;
        logic [NPINS-1:0] dat;
        logic [NPINS-1:0] evt;
        logic [NPINS-1:0] msk;
        logic [NPINS-1:0] ctl;
    } regs_t;

    regs_t r_d, r_q;

    logic [NPINS-1:0] in_rb, lvl_rb, out_rb, oe_rb, upd, evset;
    logic             wr_fire, rd_fire;
    reg_sel_e         sel;

    // pin n <-> register bit TOP-n
    for (genvar n = 0; n < NPINS; n++) begin : g_rev
        assign in_rb[TOP-n]  = pin_in_i[n];
        assign pin_out_o[n]  = out_rb[TOP-n];
        assign pin_oe_o[n]   = oe_rb[TOP-n];
    end

    gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(in_rb), .sync_o(lvl_rb)
    );

    gpio_edge #(.W(NPINS)) u_edge (
        .clk(clk), .rst_n(rst_n), .level_i(lvl_rb), .dir_i(r_q.dir),
        .fall_only_i(r_q.ctl), .upd_o(upd), .set_o(evset)
    );

    gpio_drive #(.W(NPINS)) u_drive (
        .dir_i(r_q.dir), .od_i(r_q.od), .dat_i(r_q.dat),
        .out_o(out_rb), .oe_o(oe_rb)
    );

    always_comb begin
        logic [NPINS-1:0] dat_base;
        logic [NPINS-1:0] clr;
        sel     = decode_off(bus_addr_i);
        wr_fire = bus_sel_i & bus_wr_i & bus_full_i;
        rd_fire = bus_sel_i & ~bus_wr_i & bus_full_i;

        r_d      = r_q;
        dat_base = r_q.dat;
        clr      = '0;
        if (wr_fire) begin
            case (sel)
                SEL_DIR: r_d.dir  = bus_wdata_i;
                SEL_OD:  r_d.od   = bus_wdata_i;
                SEL_DAT: dat_base = bus_wdata_i;
                SEL_EVT: clr      = bus_wdata_i;
                SEL_MSK: r_d.msk  = bus_wdata_i;
                SEL_CTL: r_d.ctl  = bus_wdata_i;
                default: ;
            endcase
        end
        r_d.dat = (dat_base & ~upd) | (lvl_rb & upd);
        r_d.evt = (r_q.evt & ~clr) | evset;

        bus_rdata_o = '0;
        if (rd_fire) begin
            case (sel)
                SEL_DIR: bus_rdata_o = r_q.dir;
                SEL_OD:  bus_rdata_o = r_q.od;
                SEL_DAT: bus_rdata_o = r_q.dat;
                SEL_EVT: bus_rdata_o = r_q.evt;
                SEL_MSK: bus_rdata_o = r_q.msk;
                SEL_CTL: bus_rdata_o = r_q.ctl;
                default: bus_rdata_o = '0;
            endcase
        end

        irq_o = |(r_q.evt & r_q.msk);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R3/R4: direction changes only through a full write at its own offset
    p_dir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_fire && sel == SEL_DIR) |=> $stable(r_q.dir));

    // R9: clearing the mask silences the interrupt on the next cycle
    p_mask_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && sel == SEL_MSK && bus_wdata_i == '0) |=> !irq_o);

    // R10: a pin that was an output cannot acquire a new event
    p_evt_input_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((r_q.evt & ~$past(r_q.evt) & $past(r_q.dir)) == '0));

    // R10: new falling-only events leave the data bit at 0
    p_fall_dat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((r_q.evt & ~$past(r_q.evt) & $past(r_q.ctl) & r_q.dat) == '0));

    // R3: a narrow read returns zero
    p_narrow_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && !bus_wr_i && !bus_full_i) |-> (bus_rdata_o == '0));
endmodule

// File: tb/gpio_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_ctrl_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        sel = 0, wr = 0, full = 0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, pout, poe, pin = '0;
    logic        irq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // model, register-bit order
    logic [31:0] m_dir = 0, m_od = 0, m_dat = 0, m_evt = 0, m_msk = 0, m_ctl = 0, m_in = 0;

    always #5 clk = ~clk;

    gpio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_wr_i(wr), .bus_full_i(full),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .pin_in_i(pin), .pin_out_o(pout), .pin_oe_o(poe), .irq_o(irq)
    );

    function automatic logic [31:0] rev(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[31-i] = v[i];
        return r;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        case (a)
            12'h000: return m_dir;
            12'h004: return m_od;
            12'h008: return m_dat;
            12'h00C: return m_evt;
            12'h010: return m_msk;
            12'h014: return m_ctl;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [11:0] a, input logic [31:0] d, input bit f);
        @(negedge clk);
        sel = 1; wr = 1; full = f; addr = a; wdata = d;
        @(negedge clk);
        sel = 0; wr = 0; full = 0;
        if (f) begin
            case (a)
                12'h000: m_dir = d;
                12'h004: m_od  = d;
                12'h008: m_dat = d;
                12'h00C: m_evt = m_evt & ~d;
                12'h010: m_msk = d;
                12'h014: m_ctl = d;
                default: ;
            endcase
        end
    endtask

    task automatic bread(input logic [11:0] a, input bit f, output logic [31:0] d);
        @(negedge clk);
        sel = 1; wr = 0; full = f; addr = a;
        #1 d = rdata;
        sel = 0; full = 0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input string req);
        logic [31:0] d;
        bread(a, 1, d);
        chk(d === exp_rd(a), req, d, exp_rd(a));
    endtask

    task automatic drive_pins(input logic [31:0] nv_rb);
        logic [31:0] chg, inp, upd, st;
        @(negedge clk);
        pin = rev(nv_rb);
        repeat (4) @(posedge clk);
        chg = nv_rb ^ m_in;
        inp = ~m_dir;
        upd = chg & inp;
        m_dat = (m_dat & ~upd) | (nv_rb & upd);
        st = inp & ((~m_ctl & chg) | (m_ctl & m_in & ~nv_rb));
        m_evt |= st;
        m_in = nv_rb;
    endtask

    task automatic pins_chk(input string tag);
        logic [31:0] eo, eoe;
        @(negedge clk);
        eo  = rev(m_dat);
        eoe = rev(m_dir & ~(m_od & m_dat));
        chk(pout === eo, {tag, " R6 pin_out"}, pout, eo);
        chk(poe === eoe, {tag, " R11 pin_oe"}, poe, eoe);
        chk(irq === |(m_evt & m_msk), {tag, " R9 irq"}, {31'b0, irq}, {31'b0, |(m_evt & m_msk)});
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [11:0] offs [8];
        void'($urandom(32'h5EED_1234));
        offs = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014, 12'h018, 12'h800};

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1 reset state
        for (int i = 0; i < 6; i++) rd_chk(offs[i], "R1 reset register");
        @(negedge clk);
        chk(poe === 0, "R1 oe after reset", poe, 0);
        chk(irq === 0, "R1 irq after reset", {31'b0, irq}, 0);

        // R2 map + R5 bit order: pin 0 is MSB
        bwrite(12'h000, 32'h8000_0001, 1);
        bwrite(12'h008, 32'h8000_0000, 1);
        rd_chk(12'h000, "R2 direction readback");
        @(negedge clk);
        chk(pout[0] === 1'b1 && poe[0] === 1'b1 && poe[31] === 1'b1, "R5 pin0 at msb", poe, 32'h8000_0001);
        chk(pout[31] === 1'b0, "R6 pin31 data low", pout, 32'h1);

        // R6 data stored in full, including input bits
        bwrite(12'h008, 32'hA5A5_5A5A, 1);
        rd_chk(12'h008, "R6 data stored in full");

        // R11 open drain
        bwrite(12'h004, 32'h8000_0001, 1);
        pins_chk("R11 open-drain");

        // R3 narrow access
        bwrite(12'h010, 32'hFFFF_FFFF, 0);
        rd_chk(12'h010, "R3 narrow write ignored");
        bread(12'h000, 0, d);
        chk(d === 0, "R3 narrow read zero", d, 0);

        // R4 unmapped
        bwrite(12'h018, 32'hFFFF_FFFF, 1);
        bwrite(12'hFFC, 32'hFFFF_FFFF, 1);
        for (int i = 0; i < 6; i++) rd_chk(offs[i], "R4 unmapped write no effect");
        bread(12'h018, 1, d);
        chk(d === 0, "R4 unmapped read zero", d, 0);

        // R7 exact latency: reg bit 0 (pin 31) is input
        bwrite(12'h000, 32'h0, 1);
        bwrite(12'h008, 32'h0, 1);
        @(negedge clk);
        pin[31] = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        sel = 1; wr = 0; full = 1; addr = 12'h008; #1;
        chk(rdata[0] === 1'b0, "R7 data before latency", rdata, 0);
        sel = 0;
        @(posedge clk); #1;
        sel = 1; full = 1; #1;
        chk(rdata[0] === 1'b1, "R7 data at latency", rdata, 1);
        sel = 0; full = 0;
        m_dat = 32'h1; m_in = 32'h1; m_evt = 32'h1;
        repeat (2) @(posedge clk);
        rd_chk(12'h00C, "R10 any-change event");

        // R8 W1C partial
        m_dat = 32'h0; bwrite(12'h008, 32'h0, 1);
        drive_pins(32'h0000_00F1);
        rd_chk(12'h00C, "R10 events rising");
        bwrite(12'h00C, 32'h0000_0030, 1);
        rd_chk(12'h00C, "R8 w1c partial");

        // R10 falling-only
        bwrite(12'h00C, 32'hFFFF_FFFF, 1);
        bwrite(12'h014, 32'h0000_00FF, 1);
        drive_pins(32'h0000_00FF);
        rd_chk(12'h00C, "R10 rise ignored in falling mode");
        drive_pins(32'h0000_000F);
        rd_chk(12'h00C, "R10 falling sets event");

        // R9 irq with mask
        bwrite(12'h010, 32'h0000_0010, 1);
        pins_chk("R9 mask set");
        bwrite(12'h010, 32'h0, 1);
        pins_chk("R9 mask clear");

        // R7/R10 output pins ignore input changes
        bwrite(12'h00C, 32'hFFFF_FFFF, 1);
        bwrite(12'h000, 32'hFFFF_0000, 1);
        drive_pins(32'h5555_AAAA);
        rd_chk(12'h008, "R7 output pins keep data");
        rd_chk(12'h00C, "R10 output pins no events");

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op = $urandom_range(0, 9);
            if (op < 5) begin
                bwrite(offs[$urandom_range(0, 7)], $urandom(), ($urandom_range(0, 5) != 0));
            end else if (op < 8) begin
                drive_pins($urandom());
            end else begin
                rd_chk(offs[$urandom_range(0, 7)], "R2 random read");
            end
            pins_chk("random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule